// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the port-to-port doorbell flags that sit beside a two-port memory. It watches the chip-select, write-strobe, output-enable and address pins of both ports. One address near the top of the memory carries messages from the left port to the right port. The address just below it carries messages from the right port to the left port. The memory array holds the mailbox data. This block only tracks whether each mailbox holds a message that has not yet been read.

When the sending port writes its outbound mailbox, the block pulls the receiving port's active-low interrupt low. When the receiving port reads that mailbox, the interrupt goes high again. Set and clear events are taken from the moment the access condition becomes true. The last of the select, strobe, enable or address inputs to arrive starts the event, and an access that is held does not repeat it. Everything is sampled on one clock. A flag changes at the first rising edge at which the completing condition is seen.

Top module: `mbox_irq_top`

## Requirements
- R1: After reset both interrupt outputs (`l_irq_n`, `r_irq_n`) are high (deasserted).
- R2: A left-port write to address 0x7FF (all address bits one) drives `r_irq_n` low at the first rising edge at which the write is seen.
- R3: A right-port read of address 0x7FF returns `r_irq_n` high at the first rising edge at which the read is seen.
- R4: A right-port write to address 0x7FE drives `l_irq_n` low at the first rising edge at which the write is seen.
- R5: A left-port read of address 0x7FE returns `l_irq_n` high at the first rising edge at which the read is seen.
- R6: A write is recognised only while that port's select (`*_ce_n`) and strobe (`*_rw_n`) are both low. If either is high, no flag is set.
- R7: A clearing read requires select low, strobe high and output enable (`*_oe_n`) low together. While output enable is high the flag stays low. The flag clears when output enable falls with the other conditions already met.
- R8: Set and clear act only when the access condition changes from false to true. If a mailbox write is held without change after its flag was cleared, the flag stays high. Moving the address away and back to the mailbox sets the flag again.
- R9: If a set and a clear of the same flag are seen at the same edge, the set wins and the flag ends low.
- R10: Other addresses leave both flags unchanged. So does a port writing its own inbound mailbox, and so does a port reading its own outbound mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce_n | input | 1 | Left port select, active low |
| l_rw_n | input | 1 | Left port strobe: low writes, high reads |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_addr | input | ADDR_W | Left port address |
| r_ce_n | input | 1 | Right port select, active low |
| r_rw_n | input | 1 | Right port strobe: low writes, high reads |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_addr | input | ADDR_W | Right port address |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Each flag is a single register that drives an output directly. A wrong set or clear decision therefore appears on the matching interrupt pin one edge after the access that caused it. A corrupted edge-history register in the access detector stays hidden until an access is held. It then shows up either as a flag that sets again while a write is held, or as an event that never happens when a condition completes. The directed scenarios hold accesses for several cycles and then move single inputs, so that both faults reach the pins within a cycle or two.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Control pins of one memory port, all active low.
  typedef struct packed {
    logic ce_n;
    logic rw_n;
    logic oe_n;
  } port_ctl_t;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_L    = 0;
  localparam int SIDE_R    = 1;

  function automatic logic is_write(port_ctl_t c);
    return !c.ce_n && !c.rw_n;
  endfunction

  function automatic logic is_read(port_ctl_t c);
    return !c.ce_n && c.rw_n && !c.oe_n;
  endfunction

endpackage

// File: rtl/mbox_access_detect.sv
module mbox_access_detect
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [ADDR_W-1:0] SEND_ADDR = {ADDR_W{1'b1}},
  parameter logic [ADDR_W-1:0] RECV_ADDR = {ADDR_W{1'b1}} - 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_ctl_t         ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              send_evt,
  output logic              recv_evt
);

  logic send_hit, recv_hit;
  logic send_hit_q, recv_hit_q;

  always_comb begin
    send_hit = is_write(ctl) && (addr == SEND_ADDR);
    recv_hit = is_read(ctl)  && (addr == RECV_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_hit_q <= 1'b0;
      recv_hit_q <= 1'b0;
    end else begin
      send_hit_q <= send_hit;
      recv_hit_q <= recv_hit;
    end
  end

  // An event fires only on the cycle the condition completes.
  assign send_evt = send_hit & ~send_hit_q;
  assign recv_evt = recv_hit & ~recv_hit_q;

  // R8: an event lasts exactly one cycle while the access is held
  a_r8_send_single: assert property (@(posedge clk) disable iff (!rst_n)
    send_evt |=> !send_evt);
  a_r8_recv_single: assert property (@(posedge clk) disable iff (!rst_n)
    recv_evt |=> !recv_evt);
  // R6: a send event needs select and strobe both low
  a_r6_send_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    send_evt |-> (!ctl.ce_n && !ctl.rw_n));
  // R7: a receive event needs output enable low
  a_r7_recv_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    recv_evt |-> (!ctl.oe_n && ctl.rw_n));

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_n <= 1'b1;
    else if (set_evt) irq_n <= 1'b0;
    else if (clr_evt) irq_n <= 1'b1;
  end

  // R9: a set wins over a clear seen at the same edge
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> !irq_n);
  // R3: a lone clear releases the flag
  a_r3_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> irq_n);
  // R10: without events the flag holds
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_evt) |=> $stable(irq_n));

endmodule

// File: rtl/mbox_irq_top.sv
module mbox_irq_top
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  // Left-to-right mailbox at the top word, right-to-left just below.
  localparam logic [ADDR_W-1:0] BOX_TO_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

  port_ctl_t         ctl    [NUM_SIDES];
  logic [ADDR_W-1:0] addr_a [NUM_SIDES];
  logic              send_e [NUM_SIDES];
  logic              recv_e [NUM_SIDES];
  logic              irq_w  [NUM_SIDES];

  assign ctl[SIDE_L]    = '{ce_n: l_ce_n, rw_n: l_rw_n, oe_n: l_oe_n};
  assign ctl[SIDE_R]    = '{ce_n: r_ce_n, rw_n: r_rw_n, oe_n: r_oe_n};
  assign addr_a[SIDE_L] = l_addr;
  assign addr_a[SIDE_R] = r_addr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int OTHER = NUM_SIDES - 1 - s;
    localparam logic [ADDR_W-1:0] OUT_BOX = (s == SIDE_L) ? BOX_TO_R : BOX_TO_L;
    localparam logic [ADDR_W-1:0] IN_BOX  = (s == SIDE_L) ? BOX_TO_L : BOX_TO_R;

    mbox_access_detect #(
      .ADDR_W   (ADDR_W),
      .SEND_ADDR(OUT_BOX),
      .RECV_ADDR(IN_BOX)
    ) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (ctl[s]),
      .addr    (addr_a[s]),
      .send_evt(send_e[s]),
      .recv_evt(recv_e[s])
    );

    mbox_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(send_e[OTHER]),
      .clr_evt(recv_e[s]),
      .irq_n  (irq_w[s])
    );
  end

  assign l_irq_n = irq_w[SIDE_L];
  assign r_irq_n = irq_w[SIDE_R];

  // R2: a left send event lowers the right interrupt at the next edge
  a_r2_left_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    send_e[SIDE_L] |=> !r_irq_n);
  // R4: a right send event lowers the left interrupt at the next edge
  a_r4_right_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    send_e[SIDE_R] |=> !l_irq_n);

endmodule

// File: tb/tb_mbox_irq_top.sv
`timescale 1ns/1ps
module tb_mbox_irq_top;

  localparam int AW = 11;
  localparam logic [AW-1:0] TO_R = 11'h7FF;
  localparam logic [AW-1:0] TO_L = 11'h7FE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
  logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mbox_irq_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(logic act, logic exp, string req, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic left_drive(logic ce, logic rw, logic oe, logic [AW-1:0] a);
    l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_addr = a;
  endtask

  task automatic right_drive(logic ce, logic rw, logic oe, logic [AW-1:0] a);
    r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_addr = a;
  endtask

  task automatic idle_both();
    left_drive(1, 1, 1, '0);
    right_drive(1, 1, 1, '0);
    tick();
  endtask

  task automatic t_reset();
    check(l_irq_n, 1'b1, "R1", "left after reset");
    check(r_irq_n, 1'b1, "R1", "right after reset");
  endtask

  task automatic t_left_to_right();
    left_drive(0, 0, 1, TO_R); tick();
    check(r_irq_n, 1'b0, "R2", "right set by left write");
    check(l_irq_n, 1'b1, "R2", "left untouched");
    left_drive(1, 1, 1, '0); tick();
    right_drive(0, 1, 0, TO_R); tick();
    check(r_irq_n, 1'b1, "R3", "right cleared by read");
    idle_both();
  endtask

  task automatic t_right_to_left();
    right_drive(0, 0, 1, TO_L); tick();
    check(l_irq_n, 1'b0, "R4", "left set by right write");
    check(r_irq_n, 1'b1, "R4", "right untouched");
    right_drive(1, 1, 1, '0); tick();
    left_drive(0, 1, 0, TO_L); tick();
    check(l_irq_n, 1'b1, "R5", "left cleared by read");
    idle_both();
  endtask

  task automatic t_write_qualify();
    left_drive(1, 0, 1, TO_R); tick();
    check(r_irq_n, 1'b1, "R6", "no set with select high");
    left_drive(0, 1, 1, TO_R); tick();
    check(r_irq_n, 1'b1, "R6", "no set with strobe high");
    left_drive(0, 0, 1, TO_R); tick();
    check(r_irq_n, 1'b0, "R6", "strobe fall completes write");
    left_drive(1, 1, 1, '0); tick();
    right_drive(0, 1, 0, TO_R); tick();
    idle_both();
  endtask

  task automatic t_read_needs_oe();
    left_drive(0, 0, 1, TO_R); tick();
    left_drive(1, 1, 1, '0);
    right_drive(0, 1, 1, TO_R); tick(2);
    check(r_irq_n, 1'b0, "R7", "no clear while oe high");
    r_oe_n = 1'b0; tick();
    check(r_irq_n, 1'b1, "R7", "oe fall completes clear");
    idle_both();
  endtask

  task automatic t_edge_only();
    left_drive(0, 0, 1, TO_R); tick();
    check(r_irq_n, 1'b0, "R8", "set by held write");
    right_drive(0, 1, 0, TO_R); tick();
    check(r_irq_n, 1'b1, "R8", "cleared while write held");
    right_drive(1, 1, 1, '0); tick(3);
    check(r_irq_n, 1'b1, "R8", "held write does not set again");
    l_addr = 11'h123; tick();
    l_addr = TO_R; tick();
    check(r_irq_n, 1'b0, "R8", "address return sets again");
    left_drive(1, 1, 1, '0); tick();
    right_drive(0, 1, 0, TO_R); tick();
    idle_both();
  endtask

  task automatic t_set_wins();
    left_drive(0, 0, 1, TO_R);
    right_drive(0, 1, 0, TO_R); tick();
    check(r_irq_n, 1'b0, "R9", "simultaneous set and clear");
    left_drive(1, 1, 1, '0);
    right_drive(1, 1, 1, '0); tick();
    right_drive(0, 1, 0, TO_R); tick();
    check(r_irq_n, 1'b1, "R9", "later clear works");
    idle_both();
  endtask

  task automatic t_other_addr();
    left_drive(0, 0, 1, TO_L); tick();
    check(l_irq_n, 1'b1, "R10", "left write own inbox, left flag");
    check(r_irq_n, 1'b1, "R10", "left write own inbox, right flag");
    left_drive(0, 0, 1, 11'h100); tick();
    check(r_irq_n, 1'b1, "R10", "left write other address");
    left_drive(1, 1, 1, '0);
    right_drive(0, 0, 1, TO_R); tick();
    check(r_irq_n, 1'b1, "R10", "right write own inbox");
    check(l_irq_n, 1'b1, "R10", "right write own inbox, left flag");
    idle_both();
    left_drive(0, 0, 1, TO_R); tick();
    left_drive(0, 1, 0, TO_R); tick();
    check(r_irq_n, 1'b0, "R10", "sender read does not clear");
    left_drive(1, 1, 1, '0);
    right_drive(0, 1, 0, TO_L); tick();
    check(r_irq_n, 1'b0, "R10", "receiver read of wrong box");
    right_drive(0, 1, 0, 11'h7FD); tick();
    check(r_irq_n, 1'b0, "R10", "read other address");
    right_drive(1, 1, 1, '0); tick();
    right_drive(0, 1, 0, TO_R); tick();
    check(r_irq_n, 1'b1, "R3", "final clear");
    idle_both();
  endtask

  initial begin
    #50000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_left_to_right();
    t_right_to_left();
    t_write_qualify();
    t_read_needs_oe();
    t_edge_only();
    t_set_wins();
    t_other_addr();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule